// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers and presents their contents, flattened, to the surrounding logic. SCL and SDA are oversampled by the system clock through two-flop synchronizers. The slave drives SDA only by pulling it low through an open-drain enable. START and STOP are recognised as SDA edges while SCL is high.

Transfers are indexed blocks. A write sends the device address, a starting register index, a byte count and then data bytes to consecutive registers. A read first writes the index, then issues a repeated START with the read address. The slave answers with the content of its byte-count register, followed by registers from the index upward, until the host declines a byte. A write-enable bit and a write-once lock bit in register 0 guard the bank. Blocked writes are still acknowledged byte by byte but leave every register untouched.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The slave answers only to 7-bit address 0x69 (address byte D2h to write, D3h to read). Any other address byte gets no acknowledge, and the rest of that transfer leaves all registers unchanged.
- R2: A write consists of address, index N, count X and data bytes. Every byte is acknowledged. Data byte k (counting from 0) lands in register N+k for k < X. Data bytes beyond the first X are acknowledged and discarded.
- R3: A read is address-write, index N, repeated START, then address-read. The first byte returned is the value of the byte-count register (index 6). The following bytes are registers N, N+1, and so on.
- R4: After the host answers a read byte with a not-acknowledge, the slave stops driving SDA until the next START or STOP.
- R5: After reset, every register reads 00h except the byte-count register at index 6, which reads 07h. SDA is not driven.
- R6: Bit 0 of register 0 is the write enable. While it is 0, a write changes only that bit, and writes to other registers or other bits have no effect.
- R7: The write enable is sampled at each START. A change made by a transfer applies from the next transfer on, not within the current one.
- R8: Bit 7 of register 0 is the lock. Once it has been written to 1 while writes are enabled, no register (the enable bit included) changes again until reset. Locked writes are still acknowledged.
- R9: The SDA drive enable changes only while SCL is low, and the idle slave never drives SDA.
- R10: An index at or beyond the register count reads back as 00h, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |
| regs_o | output | NUM_REGS*8 | Register bank, register i on bits [8i+7:8i] |

## Verification
The block transfers are tried with a foreign address, writes whose data runs shorter or longer than the stated count, reads of varying length that start inside and beyond the bank, and a changed byte-count register. These patterns separate correct address decoding, count limiting, index wrap-out and the returned count byte. Protection is probed with writes made before the enable is set, within the same transfer that sets it, and after the lock, each compared at the register outputs and by read-back. A seeded random mix of writes and reads is then compared against a bench model of the register bank.

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave #(
  parameter int NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int CNT_IDX = 6,
  parameter logic [7:0] CNT_RST = 8'h07
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int IDXW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_ACK, S_TX, S_RACK, S_WAIT} st_t;

  st_t        state;
  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  logic [3:0] bitcnt;
  logic [7:0] sh, idx, wcnt;
  logic [1:0] phase;
  logic       rd_mode, wen_eff, host_ack;
  logic [7:0] mem [NUM_REGS];

  wire scl_s   = scl_q[1];
  wire sda_s   = sda_q[1];
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire rise    = scl_s & ~scl_d;
  wire fall    = ~scl_s & scl_d;
  wire locked  = mem[0][7];
  wire idx_ok  = int'(idx) < NUM_REGS;
  wire [IDXW-1:0] ia = idx[IDXW-1:0];
  wire [7:0] rd_byte = idx_ok ? mem[ia] : 8'h00;
  wire wr_fire = !start_c && !stop_c && state == S_WR && fall && bitcnt == 4'd8
                 && phase == 2'd2 && wcnt != 8'd0;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_out
      assign regs_o[g*8 +: 8] = mem[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= (i == CNT_IDX) ? CNT_RST : 8'h00;
    end else if (wr_fire && !locked && idx_ok) begin
      if (ia == '0) begin
        if (wen_eff) mem[0] <= sh;
        else mem[0][0] <= sh[0];
      end else if (wen_eff) begin
        mem[ia] <= sh;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
      state <= S_IDLE; bitcnt <= '0; sh <= '0; idx <= '0; wcnt <= '0;
      phase <= '0; rd_mode <= 1'b0; wen_eff <= 1'b0; host_ack <= 1'b0; sda_oe <= 1'b0;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
      if (start_c) begin
        state <= S_ADDR; bitcnt <= '0; sda_oe <= 1'b0; wen_eff <= mem[0][0];
      end else if (stop_c) begin
        state <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WR: begin
            if (rise && bitcnt != 4'd8) begin
              sh <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rd_mode <= sh[0]; phase <= 2'd0; state <= S_ACK; sda_oe <= 1'b1;
                end else begin
                  state <= S_WAIT;
                end
              end else begin
                state <= S_ACK; sda_oe <= 1'b1;
                case (phase)
                  2'd0: begin idx <= sh; phase <= 2'd1; end
                  2'd1: begin wcnt <= sh; phase <= 2'd2; end
                  default: if (wcnt != 8'd0) begin
                    idx <= idx + 8'd1; wcnt <= wcnt - 8'd1;
                  end
                endcase
              end
            end
          end
          S_ACK: if (fall) begin
            if (rd_mode) begin
              state <= S_TX;
              sda_oe <= ~mem[CNT_IDX][7];
              sh <= {mem[CNT_IDX][6:0], 1'b0};
            end else begin
              state <= S_WR; sda_oe <= 1'b0;
            end
          end
          S_TX: begin
            if (rise) bitcnt <= bitcnt + 4'd1;
            else if (fall) begin
              if (bitcnt == 4'd8) begin
                bitcnt <= '0; sda_oe <= 1'b0; state <= S_RACK;
              end else begin
                sda_oe <= ~sh[7]; sh <= {sh[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (rise) host_ack <= ~sda_s;
            else if (fall) begin
              if (host_ack) begin
                state <= S_TX; sda_oe <= ~rd_byte[7];
                sh <= {rd_byte[6:0], 1'b0}; idx <= idx + 8'd1;
              end else begin
                state <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);
  p_nack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> !sda_oe);
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[7] |=> regs_o[7]);
  p_lock_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[7] |=> $stable(regs_o));

  generate
    for (g = 1; g < NUM_REGS; g++) begin : g_chk
      p_wen_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o[g*8 +: 8]) |-> $past(wen_eff));
    end
  endgenerate
endmodule

// File: tb/test_smbus_cfg_slave.sv
module test_smbus_cfg_slave;
  localparam int NR = 8;
  localparam int Q = 8;
  localparam logic [6:0] DA = 7'h69;

  logic clk = 1'b0, rst_n = 1'b0, h_scl = 1'b1, h_sda_low = 1'b0;
  logic sda_oe;
  logic [NR*8-1:0] regs_o;
  wire sda_line = ~(h_sda_low | sda_oe);

  always #2.5 clk = ~clk;

  smbus_cfg_slave #(.NUM_REGS(NR)) i_smbus_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(h_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o));

  int checks = 0, errors = 0, viol = 0;
  bit done = 1'b0;
  logic [7:0] m [NR];
  bit wen_m;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic prev_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && h_scl) viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    return (i < NR) ? m[i] : 8'h00;
  endfunction

  function automatic void model_wr(input int i, input logic [7:0] d);
    if (i >= NR || m[0][7]) return;
    if (i == 0) begin
      if (wen_m) m[0] = d; else m[0][0] = d[0];
    end else if (wen_m) m[i] = d;
  endfunction

  function automatic logic [NR*8-1:0] model_flat();
    logic [NR*8-1:0] f;
    for (int i = 0; i < NR; i++) f[i*8 +: 8] = m[i];
    return f;
  endfunction

  task automatic h_start();
    w(Q/2); h_sda_low = 1'b0; w(Q); h_scl = 1'b1; w(Q); h_sda_low = 1'b1; w(Q); h_scl = 1'b0;
  endtask

  task automatic h_stop();
    w(Q/2); h_sda_low = 1'b1; w(Q/2); h_scl = 1'b1; w(Q); h_sda_low = 1'b0; w(Q);
  endtask

  task automatic h_wbyte(input logic [7:0] b, output bit ack);
    for (int k = 7; k >= 0; k--) begin
      w(Q/2); h_sda_low = ~b[k]; w(Q/2); h_scl = 1'b1; w(Q); h_scl = 1'b0;
    end
    w(Q/2); h_sda_low = 1'b0; w(Q/2); h_scl = 1'b1; w(Q/2);
    ack = ~sda_line;
    w(Q/2); h_scl = 1'b0;
  endtask

  task automatic h_rbyte(input bit ack, output logic [7:0] b);
    w(Q/2); h_sda_low = 1'b0;
    for (int k = 7; k >= 0; k--) begin
      w(Q/2); h_scl = 1'b1; w(Q/2); b[k] = sda_line; w(Q/2); h_scl = 1'b0; w(Q/2);
    end
    h_sda_low = ack; w(Q/2); h_scl = 1'b1; w(Q); h_scl = 1'b0;
  endtask

  task automatic blk_write(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] cnt,
                           input int n, output bit all_ack, output bit addr_ack);
    bit ak;
    wen_m = m[0][0];
    h_start();
    h_wbyte({a, 1'b0}, addr_ack);
    all_ack = addr_ack;
    h_wbyte(idx, ak); all_ack &= ak;
    h_wbyte(cnt, ak); all_ack &= ak;
    for (int j = 0; j < n; j++) begin
      h_wbyte(wbuf[j], ak); all_ack &= ak;
      if (a == DA && j < int'(cnt)) model_wr(int'(idx) + j, wbuf[j]);
    end
    h_stop();
  endtask

  task automatic blk_read(input logic [7:0] idx, input int n, output bit all_ack);
    bit ak;
    logic [7:0] b;
    h_start();
    h_wbyte({DA, 1'b0}, ak); all_ack = ak;
    h_wbyte(idx, ak); all_ack &= ak;
    h_start();
    h_wbyte({DA, 1'b1}, ak); all_ack &= ak;
    h_rbyte(n > 0, b); rbuf[0] = b;
    for (int j = 1; j <= n; j++) begin
      h_rbyte(j < n, b); rbuf[j] = b;
    end
    w(4);
    chk(sda_oe == 1'b0, "R4 release after nack", sda_oe, 0);
    h_stop();
  endtask

  task automatic chk_read(input logic [7:0] idx, input int n, input string req);
    bit ak;
    blk_read(idx, n, ak);
    chk(ak, {req, " read acks"}, ak, 1);
    chk(rbuf[0] == m[6], "R3 count byte first", rbuf[0], m[6]);
    for (int j = 1; j <= n; j++)
      chk(rbuf[j] == exp_rd(int'(idx) + j - 1), req, rbuf[j], exp_rd(int'(idx) + j - 1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit aa, ad;
    int seedv;
    seedv = int'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < NR; i++) m[i] = (i == 6) ? 8'h07 : 8'h00;
    w(6); rst_n = 1'b1; w(6);

    // R5 reset state
    chk(regs_o == model_flat(), "R5 reset values", regs_o, model_flat());
    chk(sda_oe == 1'b0, "R5 sda released", sda_oe, 0);

    // R1 foreign address
    wbuf[0] = 8'h5A;
    blk_write(7'h2A, 8'h01, 8'h01, 1, aa, ad);
    chk(ad == 1'b0, "R1 foreign address not acked", ad, 0);
    chk(regs_o == model_flat(), "R1 no register change", regs_o, model_flat());

    // R6 write with enable clear, R7 enable set inside same transfer
    wbuf[0] = 8'hFF; wbuf[1] = 8'h33;
    blk_write(DA, 8'h00, 8'h02, 2, aa, ad);
    chk(aa, "R6 blocked write acked", aa, 1);
    chk(regs_o[7:0] == 8'h01, "R6 only enable bit set", regs_o[7:0], 8'h01);
    chk(regs_o[15:8] == 8'h00, "R7 enable not yet effective", regs_o[15:8], 8'h00);

    // R2 normal write
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    blk_write(DA, 8'h01, 8'h03, 3, aa, ad);
    chk(aa, "R2 all bytes acked", aa, 1);
    chk(regs_o == model_flat(), "R2 data in N..N+X-1", regs_o, model_flat());

    // R2 extra bytes beyond count
    wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
    blk_write(DA, 8'h04, 8'h01, 3, aa, ad);
    chk(aa, "R2 extra bytes acked", aa, 1);
    chk(regs_o[39:32] == 8'h44 && regs_o[47:40] == 8'h00, "R2 extra bytes dropped",
        regs_o[47:32], 16'h0044);

    // R3 read back
    chk_read(8'h01, 3, "R3 read data");

    // R3 count register change
    wbuf[0] = 8'h03;
    blk_write(DA, 8'h06, 8'h01, 1, aa, ad);
    chk_read(8'h03, 2, "R3 read after count change");

    // R10 out of range
    wbuf[0] = 8'h99;
    blk_write(DA, 8'h09, 8'h01, 1, aa, ad);
    chk(regs_o == model_flat(), "R10 out-of-range write dropped", regs_o, model_flat());
    chk_read(8'h07, 3, "R10 out-of-range reads zero");

    // random mix
    for (int it = 0; it < 24; it++) begin
      if ($urandom % 3 != 0) begin
        int n = int'($urandom % 4);
        logic [7:0] ix = 8'(1 + $urandom % 9);
        logic [7:0] c = 8'(n);
        n = n + int'($urandom % 2);
        for (int j = 0; j < n; j++) wbuf[j] = 8'($urandom);
        blk_write(DA, ix, c, n, aa, ad);
        chk(aa, "R2 random write acks", aa, 1);
        chk(regs_o == model_flat(), "R2 random write", regs_o, model_flat());
      end else begin
        chk_read(8'($urandom % 10), 1 + int'($urandom % 3), "R3 random read");
      end
    end

    // R8 lock
    wbuf[0] = 8'h81;
    blk_write(DA, 8'h00, 8'h01, 1, aa, ad);
    chk(regs_o[7:0] == 8'h81, "R8 lock set", regs_o[7:0], 8'h81);
    wbuf[0] = 8'h5C; wbuf[1] = 8'h6D;
    blk_write(DA, 8'h01, 8'h02, 2, aa, ad);
    chk(aa, "R8 locked write acked", aa, 1);
    chk(regs_o == model_flat(), "R8 locked write ignored", regs_o, model_flat());
    wbuf[0] = 8'h00;
    blk_write(DA, 8'h00, 8'h01, 1, aa, ad);
    chk(regs_o[7:0] == 8'h81, "R8 enable bit frozen", regs_o[7:0], 8'h81);
    chk_read(8'h00, 2, "R8 read after lock");

    chk(viol == 0, "R9 drive changed with SCL high", viol, 0);
    chk(sda_oe == 1'b0, "R9 idle not driving", sda_oe, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule